// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits between the host I/O decoder and the configuration paths of a host bridge. Host software selects a target with a full-dword write to the configuration address port. A later access to the configuration data port starts one configuration cycle, using the address register's value at that moment. The router then picks one of five destinations from the bus, device and function fields of that value and from two programmable bus limits:

- one of two built-in bridge functions (device 0 or device 1 on bus 0);
- an absent slot;
- the upstream hub link as a Type 0 request;
- the hub link as a Type 1 request;
- the secondary AGP/PCI port.

Each cycle fires exactly one single-cycle strobe toward its destination. The router then stays busy until that destination acknowledges, and ends by returning a completion pulse and read data to the host. When the enable bit of the address register is clear, data-port accesses are flagged as plain I/O and no configuration cycle starts.

States:

- `ST_IDLE`: accepts host requests.
- `ST_STROBE`: drives the destination strobe.
- `ST_WAIT`: waits for the destination acknowledge.
- `ST_RESPOND`: pulses the completion.

Transitions:

- `ST_IDLE`→`ST_RESPOND` on an address-register access or an absent-device cycle.
- `ST_IDLE`→`ST_STROBE` on any other enabled data-port access.
- `ST_STROBE`→`ST_WAIT` always.
- `ST_WAIT`→`ST_RESPOND` on acknowledge.
- `ST_RESPOND`→`ST_IDLE` always.

Top module: `cfg_cycle_router`

## Requirements
- R1: The 32-bit configuration address register (reset value 0) is written only by a host write to the address port with all four byte enables set. A write with any other byte enables leaves the register unchanged and gets no completion. A full-dword read of the address port completes one cycle later with the register value on `host_rdata`.
- R2: When bit 31 of the configuration address register is 0, a data-port access raises `pass_stb` for one cycle, drives no destination strobe, and leaves `host_busy` low.
- R3: With the enable bit set, bus number (bits 23:16) equal to 0 and device number (bits 15:11) equal to 0 or 1, the cycle strobes `loc_stb[0]` or `loc_stb[1]` respectively. The hub link sees no request.
- R4: Bus 0, device 2 is absent. No strobe is issued, and the host gets a completion one cycle after the request, with read data of all ones.
- R5: Bus 0 with device 3 to 31 raises `hub_req_valid`. `hub_req_addr` is then formed as follows: bits 31:16 are zero, bits 15:2 equal configuration address bits 15:2, and bits 1:0 are 00.
- R6: A non-zero bus number that is below `sec_bus` or above `sub_bus` raises `hub_req_valid`. `hub_req_addr` bits 31:2 then equal configuration address bits 31:2, and bits 1:0 are 01. This includes every non-zero bus when `sec_bus` > `sub_bus`.
- R7: A non-zero bus number with `sec_bus` <= bus <= `sub_bus` strobes `sec_stb` and never `hub_req_valid`.
- R8: Each accepted configuration cycle drives exactly one destination strobe, high for exactly the one cycle after the request. `cyc_cfg_addr` carries the address register value captured at the request.
- R9: After a strobe, `host_busy` stays high until `dest_ack`, and host requests made while busy are ignored. The cycle after `dest_ack` is sampled, `host_done` pulses with `host_rdata` equal to the `dest_rdata` captured with the acknowledge.
- R10: After reset, `host_busy`, `host_done`, `pass_stb` and all destination strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host I/O request, one cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_port | input | 16 | Host I/O port address |
| host_be | input | 4 | Byte enables |
| host_wdata | input | 32 | Write data |
| sec_bus | input | 8 | Lowest bus number behind the secondary port |
| sub_bus | input | 8 | Highest bus number behind the secondary port |
| dest_ack | input | 1 | Acknowledge from the strobed destination |
| dest_rdata | input | 32 | Read data from the destination, valid with `dest_ack` |
| host_busy | output | 1 | Router is busy; requests are ignored |
| host_done | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_done` |
| pass_stb | output | 1 | Data-port access passed through as plain I/O |
| loc_stb | output | 2 | Strobes to built-in functions 0 and 1 |
| sec_stb | output | 1 | Strobe to the secondary port |
| hub_req_valid | output | 1 | Hub link request strobe |
| hub_req_addr | output | 32 | Hub request packet address |
| cyc_cfg_addr | output | 32 | Captured configuration address of the current cycle |
| cyc_wr | output | 1 | Direction of the current cycle |
| cyc_be | output | 4 | Byte enables of the current cycle |
| cyc_wdata | output | 32 | Write data of the current cycle |

## Verification
The assertions take for granted that each destination raises `dest_ack` only after its own strobe, and that the host holds `host_req` for a single cycle per access. Under those conditions, at most one strobe is active and it is never repeated. The stimulus issues every request as a one-cycle pulse and returns the acknowledge only in the wait state after a strobe. When the bench tests the busy rule, the extra request it makes is itself a single-cycle pulse.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_LOCAL0,
        RT_LOCAL1,
        RT_ABSENT,
        RT_HUB_T0,
        RT_HUB_T1,
        RT_SECONDARY
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT,
        ST_RESPOND
    } state_t;

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            hit,
    input  logic            wr,
    input  logic [DW/8-1:0] be,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   q
);
    localparam int BEW = DW / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (accept && hit && wr && (be == {BEW{1'b1}})) begin
            q <= wdata;
        end
    end

    // R1: a write with partial byte enables leaves the register untouched
    a_r1_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && wr && (be != {BEW{1'b1}})) |=> $stable(q));

endmodule

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_router_pkg::*;
#(
    parameter int DW         = 32,
    parameter int BUS_W      = 8,
    parameter int DEV_W      = 5,
    parameter int BUS_LSB    = 16,
    parameter int DEV_LSB    = 11,
    parameter int ABSENT_DEV = 2
) (
    input  logic [DW-1:0]    cfg_addr,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output route_t           route,
    output logic [DW-1:0]    hub_addr
);
    localparam int T0_HI = BUS_LSB - 1;

    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;

    assign bus = cfg_addr[BUS_LSB +: BUS_W];
    assign dev = cfg_addr[DEV_LSB +: DEV_W];

    always_comb begin
        route    = RT_NONE;
        hub_addr = '0;
        if (bus == '0) begin
            if (dev == DEV_W'(0)) begin
                route = RT_LOCAL0;
            end else if (dev == DEV_W'(1)) begin
                route = RT_LOCAL1;
            end else if (dev == DEV_W'(ABSENT_DEV)) begin
                route = RT_ABSENT;
            end else begin
                route    = RT_HUB_T0;
                hub_addr = {{(DW - BUS_LSB){1'b0}}, cfg_addr[T0_HI:2], 2'b00};
            end
        end else if ((bus >= sec_bus) && (bus <= sub_bus)) begin
            route = RT_SECONDARY;
        end else begin
            route    = RT_HUB_T1;
            hub_addr = {cfg_addr[DW-1:2], 2'b01};
        end
    end

endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
    import cfg_router_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          PORT_W    = 16,
    parameter int          BUS_W     = 8,
    parameter int          N_LOCAL   = 2,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [PORT_W-1:0]  host_port,
    input  logic [DW/8-1:0]    host_be,
    input  logic [DW-1:0]      host_wdata,
    input  logic [BUS_W-1:0]   sec_bus,
    input  logic [BUS_W-1:0]   sub_bus,
    input  logic               dest_ack,
    input  logic [DW-1:0]      dest_rdata,
    output logic               host_busy,
    output logic               host_done,
    output logic [DW-1:0]      host_rdata,
    output logic               pass_stb,
    output logic [N_LOCAL-1:0] loc_stb,
    output logic               sec_stb,
    output logic               hub_req_valid,
    output logic [DW-1:0]      hub_req_addr,
    output logic [DW-1:0]      cyc_cfg_addr,
    output logic               cyc_wr,
    output logic [DW/8-1:0]    cyc_be,
    output logic [DW-1:0]      cyc_wdata
);
    localparam int BEW    = DW / 8;
    localparam int EN_BIT = DW - 1;
    localparam int N_DEST = N_LOCAL + 2;

    state_t           state, state_nx;
    route_t           route_dec, route_q;
    logic [DW-1:0]    addr_q, hub_dec, hub_q, rdata_q;
    logic             accept, addr_hit, data_hit, addr_acc, cfg_start, pass_q;
    logic [N_DEST-1:0] dest_vec;

    assign accept    = host_req && (state == ST_IDLE);
    assign addr_hit  = (host_port == PORT_W'(ADDR_PORT));
    assign data_hit  = (host_port == PORT_W'(DATA_PORT));
    assign addr_acc  = accept && addr_hit && (host_be == {BEW{1'b1}});
    assign cfg_start = accept && data_hit && addr_q[EN_BIT];

    cfg_addr_reg #(.DW(DW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .accept(accept),
        .hit   (addr_hit),
        .wr    (host_wr),
        .be    (host_be),
        .wdata (host_wdata),
        .q     (addr_q)
    );

    cfg_route_decode #(.DW(DW), .BUS_W(BUS_W)) u_dec (
        .cfg_addr(addr_q),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .route   (route_dec),
        .hub_addr(hub_dec)
    );

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (addr_acc) begin
                    state_nx = ST_RESPOND;
                end else if (cfg_start) begin
                    state_nx = (route_dec == RT_ABSENT) ? ST_RESPOND : ST_STROBE;
                end
            end
            ST_STROBE:  state_nx = ST_WAIT;
            ST_WAIT:    state_nx = dest_ack ? ST_RESPOND : ST_WAIT;
            ST_RESPOND: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // cycle context capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q      <= RT_NONE;
            hub_q        <= '0;
            rdata_q      <= '0;
            cyc_cfg_addr <= '0;
            cyc_wr       <= 1'b0;
            cyc_be       <= '0;
            cyc_wdata    <= '0;
            pass_q       <= 1'b0;
        end else begin
            pass_q <= accept && data_hit && !addr_q[EN_BIT];
            if (addr_acc) begin
                rdata_q <= addr_q;
                route_q <= RT_NONE;
            end else if (cfg_start) begin
                route_q      <= route_dec;
                hub_q        <= hub_dec;
                cyc_cfg_addr <= addr_q;
                cyc_wr       <= host_wr;
                cyc_be       <= host_be;
                cyc_wdata    <= host_wdata;
                rdata_q      <= '1;
            end else if ((state == ST_WAIT) && dest_ack) begin
                rdata_q <= dest_rdata;
            end
        end
    end

    // outputs from state
    always_comb begin
        loc_stb       = '0;
        sec_stb       = 1'b0;
        hub_req_valid = 1'b0;
        host_busy     = (state != ST_IDLE);
        host_done     = (state == ST_RESPOND);
        unique case (state)
            ST_STROBE: begin
                loc_stb[0]    = (route_q == RT_LOCAL0);
                loc_stb[1]    = (route_q == RT_LOCAL1);
                sec_stb       = (route_q == RT_SECONDARY);
                hub_req_valid = (route_q == RT_HUB_T0) || (route_q == RT_HUB_T1);
            end
            default: ;
        endcase
    end

    assign host_rdata   = rdata_q;
    assign pass_stb     = pass_q;
    assign hub_req_addr = hub_q;
    assign dest_vec     = {hub_req_valid, sec_stb, loc_stb};

    // R8: never more than one destination strobed
    a_r8_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dest_vec));

    // R8: a strobe lasts exactly one cycle
    a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|dest_vec) |=> !(|dest_vec));

    // R9: busy holds while a strobed destination has not acknowledged
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dest_vec) || (host_busy && !host_done && !dest_ack && !(|dest_vec)))
            |=> host_busy);

    // R5 / R6: hub packets carry type code 00 or 01 only
    a_r6_hub_code: assert property (@(posedge clk) disable iff (!rst_n)
        hub_req_valid |-> (hub_req_addr[1] == 1'b0));

    // R2: a pass-through never coincides with a configuration strobe or busy
    a_r2_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pass_stb |-> (!(|dest_vec) && !host_busy));

endmodule

// File: tb/sim_cfg_cycle_router.sv
module sim_cfg_cycle_router;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] AP = 16'h0CF8;
    localparam logic [15:0] DP = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [15:0] host_port = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  sec_bus = 8'd5, sub_bus = 8'd9;
    logic        dest_ack = 1'b0;
    logic [31:0] dest_rdata = '0;
    logic        host_busy, host_done, pass_stb, sec_stb, hub_req_valid, cyc_wr;
    logic [31:0] host_rdata, hub_req_addr, cyc_cfg_addr, cyc_wdata;
    logic [1:0]  loc_stb;
    logic [3:0]  cyc_be;
    logic [3:0]  obs;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_cycle_router u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_port(host_port), .host_be(host_be), .host_wdata(host_wdata),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .dest_ack(dest_ack),
        .dest_rdata(dest_rdata), .host_busy(host_busy), .host_done(host_done),
        .host_rdata(host_rdata), .pass_stb(pass_stb), .loc_stb(loc_stb),
        .sec_stb(sec_stb), .hub_req_valid(hub_req_valid),
        .hub_req_addr(hub_req_addr), .cyc_cfg_addr(cyc_cfg_addr),
        .cyc_wr(cyc_wr), .cyc_be(cyc_be), .cyc_wdata(cyc_wdata)
    );

    // {sec, hub, local1, local0}
    assign obs = {sec_stb, hub_req_valid, loc_stb[1], loc_stb[0]};

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one-cycle request; returns at the negedge after the capturing edge
    task automatic host_io(logic wr, logic [15:0] port, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_port = port; host_be = be; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic set_addr(logic [31:0] a);
        host_io(1'b1, AP, 4'hF, a);
        @(negedge clk);
    endtask

    task automatic run_cfg(string tag, logic [31:0] ca, logic wr, logic [3:0] ev,
                           logic [31:0] ehub, logic [31:0] resp);
        set_addr(ca);
        host_io(wr, DP, 4'hF, 32'h1234_5678);
        chk({tag, " R8 strobe set"}, {28'd0, obs}, {28'd0, ev});
        if (ev[2]) chk({tag, " hub address"}, hub_req_addr, ehub);
        if (ev != 4'd0) begin
            chk({tag, " R8 captured address"}, cyc_cfg_addr, ca);
            @(negedge clk);
            chk({tag, " R8 strobe cleared"}, {28'd0, obs}, 32'd0);
            chk({tag, " R9 busy in wait"}, {31'd0, host_busy}, 32'd1);
            dest_ack = 1'b1; dest_rdata = resp;
            @(negedge clk);
            dest_ack = 1'b0;
        end
        chk({tag, " R9 done"}, {31'd0, host_done}, 32'd1);
        if (!wr) chk({tag, " R9 read data"}, host_rdata, (ev == 4'd0) ? 32'hFFFF_FFFF : resp);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 busy", {31'd0, host_busy}, 32'd0);
        chk("R10 done", {31'd0, host_done}, 32'd0);
        chk("R10 strobes", {27'd0, pass_stb, obs}, 32'd0);
        host_io(1'b0, AP, 4'hF, '0);
        chk("R1 reset value", host_rdata, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_addr_reg();
        set_addr(32'h8001_2345);
        host_io(1'b0, AP, 4'hF, '0);
        chk("R1 readback", host_rdata, 32'h8001_2345);
        @(negedge clk);
        host_io(1'b1, AP, 4'h3, 32'hDEAD_BEEF);
        chk("R1 partial write no completion", {31'd0, host_done}, 32'd0);
        host_io(1'b0, AP, 4'hF, '0);
        chk("R1 partial write ignored", host_rdata, 32'h8001_2345);
        @(negedge clk);
    endtask

    task automatic t_pass();
        set_addr(32'h0000_1800);
        host_io(1'b0, DP, 4'hF, '0);
        chk("R2 pass strobe", {31'd0, pass_stb}, 32'd1);
        chk("R2 no destination", {28'd0, obs}, 32'd0);
        chk("R2 not busy", {31'd0, host_busy}, 32'd0);
        @(negedge clk);
        chk("R2 pass one cycle", {31'd0, pass_stb}, 32'd0);
    endtask

    task automatic t_local();
        run_cfg("R3 dev0 read", 32'h8000_0010, 1'b0, 4'b0001, '0, 32'hA5A5_0000);
        run_cfg("R3 dev1 write", 32'h8000_0A3C, 1'b1, 4'b0010, '0, 32'h0);
        chk("R8 captured write data", cyc_wdata, 32'h1234_5678);
    endtask

    task automatic t_absent();
        run_cfg("R4 dev2 read", 32'h8000_1004, 1'b0, 4'b0000, '0, 32'h0);
    endtask

    task automatic t_type0();
        logic [31:0] a;
        a = 32'h8000_1B48;   // dev 3, func 3, reg 0x48
        run_cfg("R5 dev3", a, 1'b0, 4'b0100, {16'd0, a[15:2], 2'b00}, 32'h1111_2222);
        a = 32'h8000_FFFC;   // dev 31, func 7, reg 0xFC
        run_cfg("R5 dev31", a, 1'b1, 4'b0100, {16'd0, a[15:2], 2'b00}, 32'h0);
    endtask

    task automatic t_ranges();
        logic [31:0] a;
        sec_bus = 8'd5; sub_bus = 8'd9;
        a = 32'h8004_0808;
        run_cfg("R6 below secondary", a, 1'b0, 4'b0100, {a[31:2], 2'b01}, 32'h3333_4444);
        a = 32'h800A_2010;
        run_cfg("R6 above subordinate", a, 1'b0, 4'b0100, {a[31:2], 2'b01}, 32'h5555_6666);
        run_cfg("R7 lower edge", 32'h8005_0000, 1'b0, 4'b1000, '0, 32'h7777_8888);
        run_cfg("R7 upper edge", 32'h8009_0000, 1'b1, 4'b1000, '0, 32'h0);
        run_cfg("R7 middle", 32'h8007_0804, 1'b0, 4'b1000, '0, 32'h9999_AAAA);
        sec_bus = 8'd9; sub_bus = 8'd5;
        a = 32'h8007_0000;
        run_cfg("R6 empty window", a, 1'b0, 4'b0100, {a[31:2], 2'b01}, 32'hBBBB_CCCC);
        sec_bus = 8'd5; sub_bus = 8'd9;
    endtask

    task automatic t_busy();
        set_addr(32'h8006_0000);
        host_io(1'b0, DP, 4'hF, '0);
        chk("R9 first strobe", {28'd0, obs}, 32'h8);
        host_io(1'b0, DP, 4'hF, '0);         // request while busy
        chk("R9 no strobe while busy", {28'd0, obs}, 32'd0);
        host_io(1'b1, AP, 4'hF, 32'h8000_0000); // address write while busy
        repeat (3) @(negedge clk);
        chk("R9 still busy", {31'd0, host_busy}, 32'd1);
        chk("R9 no done before ack", {31'd0, host_done}, 32'd0);
        dest_ack = 1'b1; dest_rdata = 32'h0BAD_F00D;
        @(negedge clk);
        dest_ack = 1'b0;
        chk("R9 done after ack", {31'd0, host_done}, 32'd1);
        chk("R9 ack data", host_rdata, 32'h0BAD_F00D);
        @(negedge clk);
        chk("R9 idle after done", {31'd0, host_busy}, 32'd0);
        host_io(1'b0, AP, 4'hF, '0);
        chk("R9 busy write ignored", host_rdata, 32'h8006_0000);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_reg();
        t_pass();
        t_local();
        t_absent();
        t_type0();
        t_ranges();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule